// File: doc/BRIEF.md
# Output DMA Grouping and Stride Calculator

This block turns the geometry of an image that has been decoded into 8x8 blocks into the figures a write-DMA engine and a frame-buffer allocator need. Its inputs are the classified colour code of the source, the requested output pixel format, the chroma width-halving shift, the MCU grid size (columns and rows), the per-component sampling factors and the component count. From these it picks how many MCUs one write burst group covers. It then finds how many groups span a row of MCUs and how many MCUs the final, possibly short, group holds. It packs these three figures into a control word, with each field stored as its value minus one.

For each of the three planes it also computes the padded width, the line stride and the plane size. It derives the total decoded buffer size and the decoded width and height. A one-cycle `start` pulse captures the inputs. Every result is registered together with a one-cycle `done` pulse, and the results hold until the next `start`. A chroma halving shift above 3 on an active chroma plane is reported as an error.

Top module: `dmagrp_calc`

## Requirements
- R1: A `start` sampled high at a rising edge makes `done` high for the following cycle only and updates every result at that same edge. While `start` is low, `done` is 0 and all results keep their values whatever the other inputs do.
- R2: The group exponent is chosen as follows, with the format encoding none=0, grey=1, 4:2:0=2, 4:2:2=3.
  - It is 4 for code 0x111111 with format 4:2:2.
  - It is 4 for code 0x121111 with format 4:2:0.
  - It is 2 for code 0x412121 with format 4:2:2.
  - It is 4 for code 0x110000, or for any code whose bits 15:0 are zero.
  - It is 3 otherwise. The conditions are tried in that order.
  - `grp_mcus` equals 2 to the power of the exponent.
- R3: `grp_count` is the MCU column count divided by `grp_mcus`, plus one when there is a remainder. `last_mcus` is that remainder, or `grp_mcus` when the remainder is zero.
- R4: `dma_ctrl` holds (grp_mcus-1) mod 256 in bits 23:16, (grp_count-1) mod 128 in bits 14:8 and (last_mcus-1) mod 256 in bits 7:0. All other bits are 0.
- R5: For an active plane p, `plane_width[p]` is computed in three steps.
  - Multiply the MCU columns by 8 and by the plane's width factor.
  - Shift right by the plane's halving shift, which is 0 for plane 0 and `uv_halve` for planes 1 and 2.
  - Round up to a multiple of 8.
- R6: `plane_stride[0]` is `plane_width[0]` rounded up to a multiple of 32. The stride of each active chroma plane is its width rounded up to a multiple of 16.
- R7: `plane_size[p]` is stride x 8 x height factor x MCU rows. `total_size` is `plane_size[0]` plus twice `plane_size[1]`.
- R8: `dec_width` equals `plane_stride[0]`. `dec_height` is 8 x component-0 height factor x MCU rows.
- R9: `shift_err` is set when `comp_count` is at least 2 and `uv_halve` exceeds 3. A result with the error set reports zero for every plane width, stride and size, and for `total_size`, `dec_width` and `dec_height`. With `comp_count` = 1, `uv_halve` has no effect.
- R10: A plane whose index is not below `comp_count` reports zero width, stride and size.
- R11: After reset, `done`, `shift_err` and every result output are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Capture inputs and compute |
| color_code | input | 24 | Classified colour code of the source |
| out_fmt | input | 2 | Output format: 0 none, 1 grey, 2 4:2:0, 3 4:2:2 |
| uv_halve | input | SHF_W | Chroma width-halving shift |
| mcu_cols | input | COL_W | MCU columns |
| mcu_rows | input | ROW_W | MCU rows |
| samp_w | input | 3*SF_W | Width factors, plane p at [p] |
| samp_h | input | 3*SF_W | Height factors, plane p at [p] |
| comp_count | input | 2 | Number of components (1 to 3) |
| done | output | 1 | Result valid pulse |
| shift_err | output | 1 | Invalid halving shift |
| grp_mcus | output | 5 | MCUs per DMA group |
| grp_count | output | COL_W | Number of groups |
| last_mcus | output | 5 | MCUs in last group |
| dma_ctrl | output | 32 | Packed grouping control word |
| plane_width | output | 3*WID_W | Padded plane widths |
| plane_stride | output | 3*STR_W | Plane strides |
| plane_size | output | 3*SZ_W | Plane sizes |
| total_size | output | TOT_W | Total decoded size |
| dec_width | output | STR_W | Decoded width |
| dec_height | output | DH_W | Decoded height |

## Verification
The hardest situations to reach are the ones where the format pair, and not the colour code alone, decides the group size. Examples are a 4:4:4 code sent to 4:2:0 output, which falls back to the default, and an unknown code whose low half is zero, which takes the greyscale group. The stimulus walks these pairs deliberately. It also drives column counts that are exact multiples of the group, one less than a multiple, zero and the maximum, so both the remainder path and the wrap of the 7-bit count field are reached. Error and unused-plane cases are mixed with back-to-back starts and idle cycles, during which the inputs change but the outputs must not.

// File: rtl/dmagrp_pkg.sv
package dmagrp_pkg;
    typedef enum logic [1:0] {
        OUT_NONE = 2'd0,
        OUT_GREY = 2'd1,
        OUT_420  = 2'd2,
        OUT_422  = 2'd3
    } out_fmt_e;

    localparam logic [23:0] CC_FULL   = 24'h111111;
    localparam logic [23:0] CC_TALL   = 24'h121111;
    localparam logic [23:0] CC_WIDE2  = 24'h412121;
    localparam logic [23:0] CC_MONO   = 24'h110000;
    localparam int          GS_W      = 5;
endpackage

// File: rtl/dmagrp_group.sv
module dmagrp_group
    import dmagrp_pkg::*;
#(
    parameter int COL_W = 12
) (
    input  logic [23:0]       code,
    input  logic [1:0]        fmt,
    input  logic [COL_W-1:0]  cols,
    output logic [GS_W-1:0]   gsize,
    output logic [COL_W-1:0]  gcount,
    output logic [GS_W-1:0]   glast,
    output logic [31:0]       ctrl
);
    logic [2:0]       expo;
    logic [COL_W-1:0] rem_mask;
    logic [COL_W-1:0] rem;
    logic [7:0]       gs_m1, gl_m1;
    logic [COL_W-1:0] gc_m1;

    always_comb begin
        if (code == CC_FULL && fmt == OUT_422)
            expo = 3'd4;
        else if (code == CC_TALL && fmt == OUT_420)
            expo = 3'd4;
        else if (code == CC_WIDE2 && fmt == OUT_422)
            expo = 3'd2;
        else if (code == CC_MONO || code[15:0] == 16'h0)
            expo = 3'd4;
        else
            expo = 3'd3;

        gsize    = GS_W'(1) << expo;
        rem_mask = COL_W'(gsize) - COL_W'(1);
        rem      = cols & rem_mask;
        gcount   = (cols >> expo) + COL_W'(rem != '0);
        glast    = (rem != '0) ? GS_W'(rem) : gsize;

        gs_m1 = 8'(gsize) - 8'd1;
        gl_m1 = 8'(glast) - 8'd1;
        gc_m1 = gcount - COL_W'(1);
        ctrl  = {8'h00, gs_m1, 1'b0, gc_m1[6:0], gl_m1};
    end
endmodule

// File: rtl/dmagrp_plane.sv
module dmagrp_plane #(
    parameter int COL_W    = 12,
    parameter int ROW_W    = 12,
    parameter int SF_W     = 3,
    parameter int SHF_W    = 3,
    parameter bit IS_LUMA  = 1'b0,
    localparam int PAD_W   = COL_W + 3 + SF_W,
    localparam int WID_W   = PAD_W + 1,
    localparam int STR_W   = WID_W + 1,
    localparam int SZ_W    = STR_W + 3 + SF_W + ROW_W,
    localparam int ALIGN   = IS_LUMA ? 32 : 16
) (
    input  logic              active,
    input  logic [COL_W-1:0]  cols,
    input  logic [ROW_W-1:0]  rows,
    input  logic [SF_W-1:0]   wf,
    input  logic [SF_W-1:0]   hf,
    input  logic [SHF_W-1:0]  shift,
    output logic [WID_W-1:0]  width,
    output logic [STR_W-1:0]  stride,
    output logic [SZ_W-1:0]   size,
    output logic              bad
);
    logic [PAD_W-1:0] pad;
    logic [PAD_W-1:0] narrowed;
    logic [WID_W-1:0] w_r;
    logic [STR_W-1:0] s_r;
    logic [SZ_W-1:0]  z_r;

    always_comb begin
        pad      = (PAD_W'(cols) * PAD_W'(wf)) << 3;
        narrowed = pad >> shift;
        w_r      = (WID_W'(narrowed) + WID_W'(7)) & ~WID_W'(7);
        s_r      = (STR_W'(w_r) + STR_W'(ALIGN - 1)) & ~STR_W'(ALIGN - 1);
        z_r      = (SZ_W'(s_r) * SZ_W'(hf) * SZ_W'(rows)) << 3;
        bad      = active && (shift > SHF_W'(3));
        width    = (active && !bad) ? w_r : '0;
        stride   = (active && !bad) ? s_r : '0;
        size     = (active && !bad) ? z_r : '0;
    end
endmodule

// File: rtl/dmagrp_calc.sv
module dmagrp_calc
    import dmagrp_pkg::*;
#(
    parameter int COL_W  = 12,
    parameter int ROW_W  = 12,
    parameter int SF_W   = 3,
    parameter int SHF_W  = 3,
    localparam int WID_W = COL_W + 3 + SF_W + 1,
    localparam int STR_W = WID_W + 1,
    localparam int SZ_W  = STR_W + 3 + SF_W + ROW_W,
    localparam int TOT_W = SZ_W + 2,
    localparam int DH_W  = ROW_W + 3 + SF_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic [23:0]                 color_code,
    input  logic [1:0]                  out_fmt,
    input  logic [SHF_W-1:0]            uv_halve,
    input  logic [COL_W-1:0]            mcu_cols,
    input  logic [ROW_W-1:0]            mcu_rows,
    input  logic [2:0][SF_W-1:0]        samp_w,
    input  logic [2:0][SF_W-1:0]        samp_h,
    input  logic [1:0]                  comp_count,
    output logic                        done,
    output logic                        shift_err,
    output logic [GS_W-1:0]             grp_mcus,
    output logic [COL_W-1:0]            grp_count,
    output logic [GS_W-1:0]             last_mcus,
    output logic [31:0]                 dma_ctrl,
    output logic [2:0][WID_W-1:0]       plane_width,
    output logic [2:0][STR_W-1:0]       plane_stride,
    output logic [2:0][SZ_W-1:0]        plane_size,
    output logic [TOT_W-1:0]            total_size,
    output logic [STR_W-1:0]            dec_width,
    output logic [DH_W-1:0]             dec_height
);
    typedef struct packed {
        logic                  done;
        logic                  err;
        logic [GS_W-1:0]       gsize;
        logic [COL_W-1:0]      gcount;
        logic [GS_W-1:0]       glast;
        logic [31:0]           ctrl;
        logic [2:0][WID_W-1:0] w;
        logic [2:0][STR_W-1:0] s;
        logic [2:0][SZ_W-1:0]  sz;
        logic [TOT_W-1:0]      tot;
        logic [STR_W-1:0]      dw;
        logic [DH_W-1:0]       dh;
    } res_t;

    res_t res_d, res_q;

    logic [GS_W-1:0]       g_size, g_last;
    logic [COL_W-1:0]      g_count;
    logic [31:0]           g_ctrl;
    logic [2:0][WID_W-1:0] p_w;
    logic [2:0][STR_W-1:0] p_s;
    logic [2:0][SZ_W-1:0]  p_sz;
    logic [2:0]            p_bad;

    dmagrp_group #(.COL_W(COL_W)) u_group (
        .code   (color_code),
        .fmt    (out_fmt),
        .cols   (mcu_cols),
        .gsize  (g_size),
        .gcount (g_count),
        .glast  (g_last),
        .ctrl   (g_ctrl)
    );

    for (genvar p = 0; p < 3; p++) begin : g_plane
        logic [SHF_W-1:0] sh;
        assign sh = (p == 0) ? '0 : uv_halve;
        dmagrp_plane #(
            .COL_W   (COL_W),
            .ROW_W   (ROW_W),
            .SF_W    (SF_W),
            .SHF_W   (SHF_W),
            .IS_LUMA (p == 0)
        ) u_plane (
            .active (2'(p) < comp_count),
            .cols   (mcu_cols),
            .rows   (mcu_rows),
            .wf     (samp_w[p]),
            .hf     (samp_h[p]),
            .shift  (sh),
            .width  (p_w[p]),
            .stride (p_s[p]),
            .size   (p_sz[p]),
            .bad    (p_bad[p])
        );
    end

    always_comb begin
        res_d      = res_q;
        res_d.done = start;
        if (start) begin
            res_d.err    = |p_bad;
            res_d.gsize  = g_size;
            res_d.gcount = g_count;
            res_d.glast  = g_last;
            res_d.ctrl   = g_ctrl;
            if (|p_bad) begin
                res_d.w   = '0;
                res_d.s   = '0;
                res_d.sz  = '0;
                res_d.tot = '0;
                res_d.dw  = '0;
                res_d.dh  = '0;
            end else begin
                res_d.w   = p_w;
                res_d.s   = p_s;
                res_d.sz  = p_sz;
                res_d.tot = TOT_W'(p_sz[0]) + (TOT_W'(p_sz[1]) << 1);
                res_d.dw  = p_s[0];
                res_d.dh  = (DH_W'(samp_h[0]) * DH_W'(mcu_rows)) << 3;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign done         = res_q.done;
    assign shift_err    = res_q.err;
    assign grp_mcus     = res_q.gsize;
    assign grp_count    = res_q.gcount;
    assign last_mcus    = res_q.glast;
    assign dma_ctrl     = res_q.ctrl;
    assign plane_width  = res_q.w;
    assign plane_stride = res_q.s;
    assign plane_size   = res_q.sz;
    assign total_size   = res_q.tot;
    assign dec_width    = res_q.dw;
    assign dec_height   = res_q.dh;

    assert_done_after_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);
    assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ($stable(dma_ctrl) && $stable(total_size) && $stable(plane_stride) && !done));
    assert_last_in_group_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (last_mcus >= GS_W'(1) && last_mcus <= grp_mcus));
    assert_groups_cover_cols_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(mcu_cols) != '0) |->
            ((int'(grp_count) - 1) * int'(grp_mcus) + int'(last_mcus) == int'($past(mcu_cols))));
    assert_err_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        shift_err |-> (total_size == '0 && dec_width == '0 && plane_size == '0));
    assert_stride_covers_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !shift_err) |-> (STR_W'(plane_width[0]) <= plane_stride[0]));
endmodule

// File: tb/dmagrp_calc_test.sv
module dmagrp_calc_test;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [23:0]       color_code = '0;
    logic [1:0]        out_fmt = '0;
    logic [2:0]        uv_halve = '0;
    logic [11:0]       mcu_cols = '0;
    logic [11:0]       mcu_rows = '0;
    logic [2:0][2:0]   samp_w = '0;
    logic [2:0][2:0]   samp_h = '0;
    logic [1:0]        comp_count = 2'd1;
    logic              done, shift_err;
    logic [4:0]        grp_mcus, last_mcus;
    logic [11:0]       grp_count;
    logic [31:0]       dma_ctrl;
    logic [2:0][18:0]  plane_width;
    logic [2:0][19:0]  plane_stride;
    logic [2:0][37:0]  plane_size;
    logic [39:0]       total_size;
    logic [19:0]       dec_width;
    logic [17:0]       dec_height;

    dmagrp_calc uut (
        .clk(clk), .rst_n(rst_n), .start(start), .color_code(color_code),
        .out_fmt(out_fmt), .uv_halve(uv_halve), .mcu_cols(mcu_cols),
        .mcu_rows(mcu_rows), .samp_w(samp_w), .samp_h(samp_h),
        .comp_count(comp_count), .done(done), .shift_err(shift_err),
        .grp_mcus(grp_mcus), .grp_count(grp_count), .last_mcus(last_mcus),
        .dma_ctrl(dma_ctrl), .plane_width(plane_width), .plane_stride(plane_stride),
        .plane_size(plane_size), .total_size(total_size), .dec_width(dec_width),
        .dec_height(dec_height)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit finished = 1'b0;

    longint e_done, e_err, e_gs, e_gc, e_last, e_ctrl, e_tot, e_dw, e_dh;
    longint e_w[3], e_s[3], e_sz[3];
    int     e_comp = 1;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    task automatic model_compute();
        longint cols, rows, ex, rem, pad, al, sh;
        cols = longint'(mcu_cols);
        rows = longint'(mcu_rows);
        ex = 3;
        if (color_code == 24'h111111 && out_fmt == 2'd3) ex = 4;
        else if (color_code == 24'h121111 && out_fmt == 2'd2) ex = 4;
        else if (color_code == 24'h412121 && out_fmt == 2'd3) ex = 2;
        else if (color_code == 24'h110000 || color_code[15:0] == 16'h0) ex = 4;
        e_gs = longint'(1) << ex;
        e_gc = cols / e_gs;
        rem = cols % e_gs;
        if (rem != 0) e_gc++;
        e_last = (rem != 0) ? rem : e_gs;
        e_ctrl = (((e_gs - 1) & 255) << 16) | (((e_gc - 1) & 127) << 8) | ((e_last - 1) & 255);
        e_err = 0;
        e_comp = int'(comp_count);
        for (int i = 0; i < 3; i++) begin
            if (i < e_comp) begin
                sh = (i == 0) ? 0 : longint'(uv_halve);
                if (sh > 3) e_err = 1;
                pad = cols * 8 * longint'(samp_w[i]);
                e_w[i] = ((pad >> sh) + 7) / 8 * 8;
                al = (i == 0) ? 32 : 16;
                e_s[i] = (e_w[i] + al - 1) / al * al;
                e_sz[i] = e_s[i] * 8 * longint'(samp_h[i]) * rows;
            end else begin
                e_w[i] = 0; e_s[i] = 0; e_sz[i] = 0;
            end
        end
        if (e_err != 0) begin
            for (int i = 0; i < 3; i++) begin
                e_w[i] = 0; e_s[i] = 0; e_sz[i] = 0;
            end
            e_tot = 0; e_dw = 0; e_dh = 0;
        end else begin
            e_tot = e_sz[0] + 2 * e_sz[1];
            e_dw = e_s[0];
            e_dh = 8 * longint'(samp_h[0]) * rows;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            e_done = 0; e_err = 0; e_gs = 0; e_gc = 0; e_last = 0; e_ctrl = 0;
            e_tot = 0; e_dw = 0; e_dh = 0;
            for (int i = 0; i < 3; i++) begin
                e_w[i] = 0; e_s[i] = 0; e_sz[i] = 0;
            end
        end else begin
            e_done = longint'(start);
            if (start) model_compute();
        end
        if (cyc > 20000 && !finished) begin
            finished = 1'b1;
            failures++;
            $display("FAIL watchdog expired, run did not complete");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    always @(negedge clk) begin
        if (cyc >= 1 && !finished) begin
            if (!rst_n) begin
                chk(done == 1'b0 && dma_ctrl == 0 && total_size == 0 && dec_height == 0
                    && shift_err == 1'b0 && grp_mcus == 0, "R11 reset state",
                    longint'(dma_ctrl), 0);
            end else begin
                chk(longint'(done) == e_done, "R1 done pulse", longint'(done), e_done);
                chk(longint'(grp_mcus) == e_gs, "R2 group size", longint'(grp_mcus), e_gs);
                chk(longint'(grp_count) == e_gc, "R3 group count", longint'(grp_count), e_gc);
                chk(longint'(last_mcus) == e_last, "R3 last group", longint'(last_mcus), e_last);
                chk(longint'(dma_ctrl) == e_ctrl, "R4 control word", longint'(dma_ctrl), e_ctrl);
                chk(longint'(shift_err) == e_err, "R9 shift error", longint'(shift_err), e_err);
                for (int i = 0; i < 3; i++) begin
                    if (i >= e_comp) begin
                        chk(longint'(plane_width[i]) == 0 && longint'(plane_stride[i]) == 0
                            && longint'(plane_size[i]) == 0, "R10 unused plane zero",
                            longint'(plane_size[i]), 0);
                    end else begin
                        chk(longint'(plane_width[i]) == e_w[i], "R5 plane width",
                            longint'(plane_width[i]), e_w[i]);
                        chk(longint'(plane_stride[i]) == e_s[i], "R6 plane stride",
                            longint'(plane_stride[i]), e_s[i]);
                        chk(longint'(plane_size[i]) == e_sz[i], "R7 plane size",
                            longint'(plane_size[i]), e_sz[i]);
                    end
                end
                chk(longint'(total_size) == e_tot, "R7 total size", longint'(total_size), e_tot);
                chk(longint'(dec_width) == e_dw, "R8 decoded width", longint'(dec_width), e_dw);
                chk(longint'(dec_height) == e_dh, "R8 decoded height", longint'(dec_height), e_dh);
            end
        end
    end

    task automatic setup(input logic [23:0] code, input logic [1:0] fmt, input int halve,
                         input int cols, input int rows,
                         input int w0, input int h0, input int w1, input int h1,
                         input int w2, input int h2, input int comp);
        color_code = code; out_fmt = fmt; uv_halve = 3'(halve);
        mcu_cols = 12'(cols); mcu_rows = 12'(rows);
        samp_w[0] = 3'(w0); samp_h[0] = 3'(h0);
        samp_w[1] = 3'(w1); samp_h[1] = 3'(h1);
        samp_w[2] = 3'(w2); samp_h[2] = 3'(h2);
        comp_count = 2'(comp);
    endtask

    task automatic run(input logic [23:0] code, input logic [1:0] fmt, input int halve,
                       input int cols, input int rows,
                       input int w0, input int h0, input int w1, input int h1,
                       input int w2, input int h2, input int comp);
        @(negedge clk);
        setup(code, fmt, halve, cols, rows, w0, h0, w1, h1, w2, h2, comp);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R2 default exponent, R3 remainder path
        run(24'h221111, 2'd2, 0, 20, 10, 2, 2, 1, 1, 1, 1, 3);
        // R2 full-chroma to 4:2:2 with halving
        run(24'h111111, 2'd3, 1, 32, 5, 1, 1, 1, 1, 1, 1, 3);
        // R2 same code, other format falls back to default
        run(24'h111111, 2'd2, 1, 33, 5, 1, 1, 1, 1, 1, 1, 3);
        // R2 tall code to 4:2:0
        run(24'h121111, 2'd2, 1, 17, 6, 1, 2, 1, 1, 1, 1, 3);
        // R2 wide code to 4:2:2, exponent 2
        run(24'h412121, 2'd3, 0, 9, 3, 4, 1, 2, 1, 2, 1, 3);
        // R2 greyscale, R9 halve ignored with one component, R10
        run(24'h110000, 2'd1, 5, 100, 7, 1, 1, 0, 0, 0, 0, 1);
        // R2 unknown code with low half zero
        run(24'h220000, 2'd0, 0, 48, 2, 2, 2, 0, 0, 0, 0, 1);
        // R9 error on chroma halving shift 4
        run(24'h221111, 2'd2, 4, 20, 10, 2, 2, 1, 1, 1, 1, 3);
        // R5/R6 max legal shift, R10 plane 2 unused
        run(24'h211100, 2'd3, 3, 13, 4, 2, 1, 1, 1, 1, 1, 2);
        // R3 single MCU
        run(24'h221111, 2'd2, 0, 1, 1, 2, 2, 1, 1, 1, 1, 3);
        // R3/R7 maximum grid
        run(24'h441111, 2'd2, 0, 4095, 4095, 4, 4, 1, 1, 1, 1, 3);
        // R3/R4 zero columns wrap
        run(24'h221111, 2'd2, 0, 0, 3, 2, 2, 1, 1, 1, 1, 3);
        // R4 group count field wraps past 7 bits
        run(24'h221111, 2'd2, 0, 2047, 2, 2, 2, 1, 1, 1, 1, 3);
        // R1 back-to-back starts
        @(negedge clk);
        setup(24'h111111, 2'd3, 1, 40, 3, 1, 1, 1, 1, 1, 1, 3);
        start = 1'b1;
        @(negedge clk);
        setup(24'h412121, 2'd3, 0, 15, 3, 4, 1, 2, 1, 2, 1, 3);
        @(negedge clk);
        start = 1'b0;
        // R1 inputs change while idle: outputs must hold
        setup(24'h110000, 2'd1, 7, 999, 999, 3, 3, 3, 3, 3, 3, 3);
        repeat (4) @(negedge clk);
        setup(24'h121111, 2'd2, 2, 5, 5, 1, 2, 1, 1, 1, 1, 2);
        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule